// File: doc/BRIEF.md
# Prescaled Pacer Clock Timer

The block produces the periodic pulse that paces a converter. A base tick strobe, nominally every 250 ns, feeds a power-of-two prescaler, and the prescaler output steps an up-counter. When the up-counter reaches its top value it is loaded again from the timer register and a pulse lasting one clock cycle leaves the block. Software writes a 12-bit timer setting. Bits 11:8 hold the prescale exponent p, from 0 to 15. Bits 7:0 hold 255 minus the desired divider. The pacer period is therefore divider × 2^p base ticks, which is divider × 250 ns × 2^p.

While the run input is low, or while a write is accepted, the prescaler and the up-counter are held at their start values. A fresh period then begins on the next tick. When the external select input is high, the internal pacer is held and the pulse is made from rising edges of an asynchronous external clock instead. That clock is synchronised through two flops and edge-detected. The readback port returns the stored setting, and its upper four bits read as ones. After reset the upper byte of the readback is 0xF0.

Top module: `pacer_timer`

## Requirements
- R1: After reset, rd_data_o reads 0xF000 and pulse_o is low.
- R2: In internal mode with run_i high, pulse_o rises for exactly one clock, in the cycle after the tick that completes a period. The first pulse after a restart, and every later one, comes divider × 2^p ticks apart.
- R3: The exponent p is taken from wr_data_i[11:8] and the low byte L from wr_data_i[7:0]. The divider is 255 − L. L = 0xFF behaves as a divider of 1, and p = 15 divides the base tick by 32768.
- R4: A write restarts the prescaler and the counter, and a tick in the same cycle as the write is ignored. From the next cycle, rd_data_o[11:0] equals the written value.
- R5: rd_data_o[15:12] reads 4'hF after any write.
- R6: While run_i is low, pulse_o stays low and no ticks are accumulated. When run_i returns high, a full period starts.
- R7: With ext_sel_i and run_i high, each rising edge of ext_clk_i gives one pulse of one clock. The pulse appears on the third rising clock edge after the input change. Ticks give no pulse in this mode.
- R8: Rising edges of ext_clk_i give no pulse while ext_sel_i is low. When ext_sel_i is lowered, the internal pacer begins a full period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Base tick strobe, one cycle wide |
| wr_en_i | input | 1 | Write strobe for the timer setting |
| wr_data_i | input | 12 | New setting: exponent in 11:8, complemented count in 7:0 |
| run_i | input | 1 | Enable for pulse generation |
| ext_sel_i | input | 1 | Selects the external clock in place of the internal pacer |
| ext_clk_i | input | 1 | Asynchronous external pacing clock |
| pulse_o | output | 1 | Pacer pulse, one cycle per period |
| rd_data_o | output | 16 | Readback of the timer setting |

## Verification
The assertions check four rules on every cycle. A cycle with run low, or an internal-mode cycle without a tick, or an internal-mode write, is never followed by a pulse, and a write is reflected in the readback one cycle later. Only the scenarios can show the period length for several exponent and count pairs, including the two extreme settings. The same holds for the three-edge latency of the external path and for the restart after a write, after run is lowered or after a mode change. A behavioural reference model counts remaining ticks, and the bench also measures the gap between pulses directly.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    localparam int unsigned DEF_PRE_W = 4;
    localparam int unsigned DEF_CNT_W = 8;
    localparam int unsigned DEF_REG_W = 16;

    // state of the external clock synchroniser and edge detector
    typedef struct packed {
        logic meta;
        logic sync;
        logic last;
        logic pulse;
    } ext_state_t;

endpackage

// File: rtl/pacer_prescale.sv
module pacer_prescale #(
    parameter int unsigned PRE_W = pacer_pkg::DEF_PRE_W,
    localparam int unsigned DIV_W = (1 << PRE_W) - 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic [PRE_W-1:0] exp_i,
    output logic             step_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [DIV_W-1:0] mask;
    logic             at_last;

    always_comb begin
        mask    = ~({DIV_W{1'b1}} << exp_i);
        at_last = (st_q.cnt == mask);
        step_o  = tick_i & ~restart_i & at_last;
        st_d    = st_q;
        if (restart_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = at_last ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pacer_count.sv
module pacer_count #(
    parameter int unsigned CNT_W = pacer_pkg::DEF_CNT_W,
    localparam int unsigned LAST = (1 << CNT_W) - 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             pulse_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (restart_i) begin
            st_d.cnt = load_i;
        end else if (step_i) begin
            // the step that would carry the count to all ones ends the period
            if (st_q.cnt >= CNT_W'(LAST)) begin
                st_d.cnt   = load_i;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/pacer_extsync.sv
module pacer_extsync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_i,
    input  logic gate_i,
    output logic pulse_o
);

    import pacer_pkg::*;

    ext_state_t st_d, st_q;

    always_comb begin
        st_d.meta  = ext_i;
        st_d.sync  = st_q.meta;
        st_d.last  = st_q.sync;
        st_d.pulse = gate_i & st_q.sync & ~st_q.last;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/pacer_timer.sv
module pacer_timer #(
    parameter int unsigned PRE_W = pacer_pkg::DEF_PRE_W,
    parameter int unsigned CNT_W = pacer_pkg::DEF_CNT_W,
    parameter int unsigned REG_W = pacer_pkg::DEF_REG_W,
    localparam int unsigned FIELD_W = PRE_W + CNT_W,
    localparam int unsigned FILL_W = REG_W - FIELD_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick_i,
    input  logic               wr_en_i,
    input  logic [FIELD_W-1:0] wr_data_i,
    input  logic               run_i,
    input  logic               ext_sel_i,
    input  logic               ext_clk_i,
    output logic               pulse_o,
    output logic [REG_W-1:0]   rd_data_o
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] low;
    } setting_t;

    setting_t set_d, set_q;
    logic             restart;
    logic             step;
    logic [CNT_W-1:0] load;
    logic             int_pulse;
    logic             ext_pulse;

    always_comb begin
        set_d = set_q;
        if (wr_en_i) begin
            set_d = setting_t'(wr_data_i);
        end
        restart = wr_en_i | ~run_i | ext_sel_i;
        load    = wr_en_i ? wr_data_i[CNT_W-1:0] : set_q.low;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            set_q <= '0;
        end else begin
            set_q <= set_d;
        end
    end

    pacer_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .tick_i    (tick_i),
        .exp_i     (set_q.pre),
        .step_o    (step)
    );

    pacer_count #(.CNT_W(CNT_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .step_i    (step),
        .load_i    (load),
        .pulse_o   (int_pulse)
    );

    pacer_extsync u_ext (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ext_i   (ext_clk_i),
        .gate_i  (run_i & ext_sel_i),
        .pulse_o (ext_pulse)
    );

    assign pulse_o   = int_pulse | ext_pulse;
    assign rd_data_o = {{FILL_W{1'b1}}, set_q};

endmodule

// File: rtl/pacer_timer_chk.sv
module pacer_timer_chk #(
    parameter int unsigned FIELD_W = 12,
    parameter int unsigned REG_W = 16
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               tick_i,
    input logic               wr_en_i,
    input logic [FIELD_W-1:0] wr_data_i,
    input logic               run_i,
    input logic               ext_sel_i,
    input logic               pulse_o,
    input logic [REG_W-1:0]   rd_data_o
);

    // R6: a stopped pacer never pulses
    p_stopped_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> !pulse_o);

    // R2: an internal pulse only follows a tick
    p_pulse_needs_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ext_sel_i && !tick_i) |=> !pulse_o);

    // R4: a write restarts the internal pacer
    p_write_restarts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !ext_sel_i) |=> !pulse_o);

    // R4: the written setting is visible one cycle later
    p_write_readback_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (rd_data_o[FIELD_W-1:0] == $past(wr_data_i)));

endmodule

bind pacer_timer pacer_timer_chk #(.FIELD_W(FIELD_W), .REG_W(REG_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .run_i     (run_i),
    .ext_sel_i (ext_sel_i),
    .pulse_o   (pulse_o),
    .rd_data_o (rd_data_o)
);

// File: tb/pacer_timer_tb_top.sv
module pacer_timer_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [11:0] wr_data_i = '0;
    logic        run_i = 1'b0;
    logic        ext_sel_i = 1'b0;
    logic        ext_clk_i = 1'b0;
    logic        pulse_o;
    logic [15:0] rd_data_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int tick_every = 0;
    int tick_phase = 0;
    string phase = "R1";

    int m_pre, m_low, m_rem;
    bit m_s1, m_s2, m_s3;
    bit exp_pulse;
    int dut_pulses, mod_pulses;
    bit done = 0;

    always #2 clk_i = ~clk_i;

    pacer_timer dut_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .run_i     (run_i),
        .ext_sel_i (ext_sel_i),
        .ext_clk_i (ext_clk_i),
        .pulse_o   (pulse_o),
        .rd_data_o (rd_data_o)
    );

    function automatic int period_of(int p, int l);
        int d;
        d = (l == 255) ? 1 : 255 - l;
        return d << p;
    endfunction

    task automatic chk(string r, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, expv);
        end
    endtask

    // tick pattern generator
    always @(negedge clk_i) begin
        if (tick_every == 0) begin
            tick_i <= 1'b0;
        end else begin
            tick_phase = (tick_phase + 1) % tick_every;
            tick_i <= (tick_phase == 0);
        end
    end

    // behavioural reference: remaining ticks until the next pulse
    always @(posedge clk_i) begin
        bit ext_rise;
        if (!rst_ni) begin
            m_pre = 0; m_low = 0; m_rem = period_of(0, 0);
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            exp_pulse = 0;
        end else begin
            ext_rise = m_s2 && !m_s3;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk_i;
            exp_pulse = run_i && ext_sel_i && ext_rise;
            if (wr_en_i) begin
                m_pre = int'(wr_data_i[11:8]);
                m_low = int'(wr_data_i[7:0]);
                m_rem = period_of(m_pre, m_low);
            end else if (!run_i || ext_sel_i) begin
                m_rem = period_of(m_pre, m_low);
            end else if (tick_i) begin
                m_rem--;
                if (m_rem == 0) begin
                    exp_pulse = 1;
                    m_rem = period_of(m_pre, m_low);
                end
            end
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk_i) begin
        cyc++;
        if (rst_ni && !done) begin
            total++;
            if (pulse_o !== exp_pulse) begin
                bad++;
                $display("FAIL %s cycle %0d pulse actual=%b expected=%b", phase, cyc, pulse_o, exp_pulse);
            end
            if (pulse_o) dut_pulses++;
            if (exp_pulse) mod_pulses++;
        end
        if (cyc > 190000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic write_set(logic [11:0] v);
        @(negedge clk_i);
        wr_en_i = 1'b1;
        wr_data_i = v;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    // gap in clock cycles between two consecutive pulses (tick every cycle)
    task automatic gap(string r, int expv);
        int n;
        n = 0;
        while (pulse_o !== 1'b1 && n < 70000) begin @(negedge clk_i); n++; end
        @(negedge clk_i);
        n = 1;
        while (pulse_o !== 1'b1 && n < 70000) begin @(negedge clk_i); n++; end
        chk(r, n, expv);
    endtask

    initial begin
        cycles(3);
        rst_ni = 1'b1;
        @(negedge clk_i);
        // R1 reset state
        chk("R1 readback", int'(rd_data_o), 'hF000);
        chk("R1 pulse", int'(pulse_o), 0);

        // R2: divider 2, p 0, tick every cycle
        phase = "R2";
        run_i = 1'b1;
        tick_every = 1;
        write_set(12'h0FD);
        gap("R2 period div2", 2);
        cycles(20);

        // R3: divider 5, p 3, tick every cycle
        phase = "R3";
        write_set(12'h3FA);
        gap("R3 period p3 div5", 40);
        // R3: low byte 0xFF acts as divider 1
        write_set(12'h1FF);
        gap("R3 period p1 div1", 2);
        // R3: low byte 0x00, p 0 -> 255
        write_set(12'h000);
        gap("R3 period p0 div255", 255);
        // slower tick pattern, compared cycle by cycle
        tick_every = 3;
        write_set(12'h2FC);
        dut_pulses = 0; mod_pulses = 0;
        cycles(600);
        chk("R3 pulse count sparse ticks", dut_pulses, mod_pulses);

        // R4/R5: write with a tick in the same cycle, readback
        phase = "R4";
        tick_every = 1;
        write_set(12'hABC);
        chk("R4 readback", int'(rd_data_o[11:0]), 'hABC);
        chk("R5 upper nibble", int'(rd_data_o[15:12]), 'hF);
        write_set(12'h0F0);
        cycles(7);
        write_set(12'h0F0);
        gap("R4 period after rewrite", 15);

        // R6: run low
        phase = "R6";
        @(negedge clk_i);
        run_i = 1'b0;
        dut_pulses = 0;
        cycles(200);
        chk("R6 no pulse while stopped", dut_pulses, 0);
        chk("R6 setting kept", int'(rd_data_o), 'hF0F0);
        run_i = 1'b1;
        gap("R6 period after run", 15);

        // R7: external clock mode
        phase = "R7";
        @(negedge clk_i);
        ext_sel_i = 1'b1;
        cycles(6);
        dut_pulses = 0;
        for (int i = 0; i < 10; i++) begin
            ext_clk_i = 1'b1;
            cycles(3 + (i % 3));
            ext_clk_i = 1'b0;
            cycles(4);
        end
        cycles(5);
        chk("R7 one pulse per edge", dut_pulses, 10);
        // latency: third rising edge after the change
        ext_clk_i = 1'b1;
        cycles(2);
        chk("R7 no pulse before third edge", int'(pulse_o), 0);
        @(negedge clk_i);
        chk("R7 pulse at third edge", int'(pulse_o), 1);
        @(negedge clk_i);
        chk("R7 pulse lasts one cycle", int'(pulse_o), 0);
        ext_clk_i = 1'b0;
        cycles(4);

        // R8: edges ignored in internal mode, restart on mode exit
        phase = "R8";
        ext_sel_i = 1'b0;
        write_set(12'h000);
        dut_pulses = 0;
        for (int i = 0; i < 5; i++) begin
            ext_clk_i = 1'b1; cycles(4);
            ext_clk_i = 1'b0; cycles(4);
        end
        chk("R8 ext edges ignored", dut_pulses, 0);
        write_set(12'h0F6);
        cycles(4);
        @(negedge clk_i);
        ext_sel_i = 1'b1;
        cycles(3);
        ext_sel_i = 1'b0;
        gap("R8 period after mode exit", 9);

        // R3 boundary: p 15, divider 1
        phase = "R3";
        write_set(12'hFFE);
        gap("R3 period p15 div1", 32768);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule